// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. It holds 64 entries, and any virtual page may live in any of them. On each lookup, the 20-bit virtual page number is compared against every valid stored tag at the same time. A hit that passes the read/write permission check returns the stored physical page number joined to the untouched 12-bit offset. A tag hit that fails the permission check raises a protection fault. When no tag matches, the block raises a miss. The block does not walk the page table itself.

An external page-table walker installs translations through the refill port. The victim slot is chosen in this order: a slot already holding the same tag, then the lowest-numbered invalid slot, then the lowest-numbered slot whose reference bit is clear. If every reference bit is set, all reference bits are cleared and slot 0 is replaced. Every entry tracks a dirty bit and a reference bit. When a refill displaces a live translation, the block reports that translation on the eviction outputs, including its dirty state, so the owner can schedule a write-back. A global invalidate drops every translation in one cycle.

Lookup and refill are valid-qualified streams with no back-pressure. The block accepts one lookup and one refill in every cycle. The response and eviction outputs are single-cycle pulses, and their consumer must take them in the cycle they appear.

Top module: `tlb_fa`

## Requirements
- R1: After reset, rsp_valid and ev_valid are low and no slot holds a valid translation, so the first lookup reports a miss.
- R2: A lookup whose page number matches a valid slot whose rights permit the access gives, one cycle later, rsp_valid=1 and rsp_hit=1. rsp_paddr is {stored physical page, lk_vaddr[11:0]}.
- R3: When rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is high. A lookup that matches no valid slot reports rsp_miss with rsp_paddr=0.
- R4: A write (lk_write=1) to a slot whose write right is clear, or a read (lk_write=0) to a slot whose read right is clear, reports rsp_fault with rsp_paddr=0. It changes neither the slot's dirty bit nor its reference bit.
- R5: A permitted write hit sets the slot's dirty bit. The dirty bit is reported as ev_dirty when that slot is later displaced.
- R6: A refill of a new tag fills the lowest-numbered invalid slot while any slot is invalid.
- R7: Every permitted hit sets the slot's reference bit. A refill installs the new entry with its reference and dirty bits clear. With all slots valid, a new tag replaces the lowest-numbered slot whose reference bit is clear.
- R8: With all slots valid and every reference bit set, a new tag clears all reference bits and replaces slot 0.
- R9: A refill whose tag already sits in a valid slot rewrites that slot in place, with new page, rights, dirty and reference cleared. It creates no duplicate and raises no eviction report.
- R10: inv_all clears every valid bit in one cycle. A refill presented in the same cycle is discarded.
- R11: When a lookup and a refill arrive in the same cycle, the lookup is answered from the contents before the refill, and the refill victim is chosen from the state at the start of that cycle.
- R12: One cycle after a refill displaces a valid slot holding a different tag, ev_valid pulses with ev_vpn set to the displaced tag and ev_dirty set to its dirty bit. ev_valid is otherwise low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| fl_valid | input | 1 | Refill request present |
| fl_vpn | input | 20 | Virtual page number to install |
| fl_ppn | input | 20 | Physical page number to install |
| fl_rd | input | 1 | Read right of the new entry |
| fl_wr | input | 1 | Write right of the new entry |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No valid tag matched |
| rsp_fault | output | 1 | Tag matched, rights refused |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| ev_valid | output | 1 | A live translation was displaced |
| ev_vpn | output | 20 | Tag of the displaced translation |
| ev_dirty | output | 1 | Dirty bit of the displaced translation |

## Verification
Lookup results are due exactly one cycle after the request edge, and eviction reports exactly one cycle after the refill edge. Both come from a single register stage. The bench applies a request at a falling edge and computes its expected response from a shadow table at that moment. It then waits for the next rising edge and compares at the following falling edge, before the next request. The shadow table is updated in the same order the block uses: lookup effects first, then refill, then invalidate.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_VA_W    = 32;
  localparam int unsigned DEF_PA_W    = 32;
  localparam int unsigned DEF_OFF_W   = 12;
  localparam int unsigned DEF_ENTRIES = 64;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_FAULT = 2'd3
  } tlb_res_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
  input  logic [ENTRIES-1:0]              valids,
  input  logic [TAG_W-1:0]                key,
  output logic                            hit,
  output logic [IDX_W-1:0]                hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valids[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  // R9
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valids,
  input  logic [ENTRIES-1:0] refs,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               wrap
);
  logic [IDX_W-1:0] inv_idx, clr_idx;
  logic             any_inv, any_clr;

  always_comb begin
    inv_idx = '0;
    clr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valids[i]) inv_idx = IDX_W'(i);
      if (!refs[i])   clr_idx = IDX_W'(i);
    end
  end

  assign any_inv = ~&valids;
  assign any_clr = ~&refs;

  always_comb begin
    wrap = 1'b0;
    if (any_inv)      victim_idx = inv_idx;
    else if (any_clr) victim_idx = clr_idx;
    else begin
      victim_idx = '0;
      wrap       = 1'b1;
    end
  end

  // R6
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_inv |-> !valids[victim_idx]);

  // R7
  victim_unref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_inv && any_clr) |-> !refs[victim_idx]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = DEF_VA_W,
  parameter int unsigned PA_W    = DEF_PA_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              fl_valid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic              fl_rd,
  input  logic              fl_wr,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              ev_valid,
  output logic [VPN_W-1:0]  ev_vpn,
  output logic              ev_dirty
);
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            rd_q, wr_q;
  logic [ENTRIES-1:0]            valid_q, dirty_q, ref_q;
  logic [ENTRIES-1:0]            valid_d, dirty_d, ref_d;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_tag_hit, fl_tag_hit, perm_ok, wrap;
  logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx, sel_idx;
  logic             fill_go;
  tlb_res_e         res;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .tags(tag_q), .valids(valid_q),
    .key(lk_vpn), .hit(lk_tag_hit), .hit_idx(lk_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_fl_match (
    .clk(clk), .rst_n(rst_n), .tags(tag_q), .valids(valid_q),
    .key(fl_vpn), .hit(fl_tag_hit), .hit_idx(fl_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valids(valid_q), .refs(ref_q),
    .victim_idx(vic_idx), .wrap(wrap)
  );

  assign perm_ok = lk_write ? wr_q[lk_idx] : rd_q[lk_idx];
  assign sel_idx = fl_tag_hit ? fl_idx : vic_idx;
  assign fill_go = fl_valid && !inv_all;

  always_comb begin
    if (!lk_valid)        res = RES_NONE;
    else if (!lk_tag_hit) res = RES_MISS;
    else if (perm_ok)     res = RES_HIT;
    else                  res = RES_FAULT;
  end

  // Flag update order: lookup effects, then refill, then invalidate.
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    ref_d   = ref_q;
    if (res == RES_HIT) begin
      ref_d[lk_idx] = 1'b1;
      if (lk_write) dirty_d[lk_idx] = 1'b1;
    end
    if (fill_go) begin
      if (!fl_tag_hit && wrap) ref_d = '0;
      valid_d[sel_idx] = 1'b1;
      dirty_d[sel_idx] = 1'b0;
      ref_d[sel_idx]   = 1'b0;
    end
    if (inv_all) valid_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      dirty_q   <= '0;
      ref_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      ev_valid  <= 1'b0;
      ev_vpn    <= '0;
      ev_dirty  <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      dirty_q   <= dirty_d;
      ref_q     <= ref_d;
      rsp_valid <= lk_valid;
      rsp_hit   <= (res == RES_HIT);
      rsp_miss  <= (res == RES_MISS);
      rsp_fault <= (res == RES_FAULT);
      rsp_paddr <= (res == RES_HIT) ? {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
      ev_valid  <= fill_go && !fl_tag_hit && valid_q[sel_idx];
      ev_vpn    <= tag_q[sel_idx];
      ev_dirty  <= dirty_q[sel_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[sel_idx] <= fl_vpn;
      ppn_q[sel_idx] <= fl_ppn;
      rd_q[sel_idx]  <= fl_rd;
      wr_q[sel_idx]  <= fl_wr;
    end
  end

  // R2
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R4
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0));

  // R12
  evict_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(fl_valid && !inv_all));

  // R10
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) |-> !ev_valid);
endmodule

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fl_valid = 1'b0, fl_rd = 1'b0, fl_wr = 1'b0, inv_all = 1'b0;
  logic [19:0] fl_vpn = '0, fl_ppn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, ev_valid, ev_dirty;
  logic [31:0] rsp_paddr;
  logic [19:0] ev_vpn;

  always #4 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .inv_all(inv_all), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_dirty(ev_dirty)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bit        m_v[N], m_r[N], m_w[N], m_d[N], m_ref[N];
  bit [19:0] m_tag[N], m_ppn[N];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find_tag(bit [19:0] t);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int pick_victim(output bit wrap);
    wrap = 1'b0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_ref[i]) return i;
    wrap = 1'b1;
    return 0;
  endfunction

  // One cycle: drive at falling edge, predict, clock, compare at next falling edge.
  task automatic step(bit lv, bit [31:0] va, bit lw, bit fv, bit [19:0] fvpn,
                      bit [19:0] fppn, bit fr, bit fw, bit inv, string req);
    int h, fh, sel;
    bit wrap, ok;
    bit e_hit, e_miss, e_fault, e_ev, e_evd;
    bit [31:0] e_pa;
    bit [19:0] e_evv;
    string t;
    lk_valid = lv; lk_vaddr = va; lk_write = lw;
    fl_valid = fv; fl_vpn = fvpn; fl_ppn = fppn; fl_rd = fr; fl_wr = fw;
    inv_all = inv;
    e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
    h = find_tag(va[31:12]);
    if (lv) begin
      if (h < 0) e_miss = 1;
      else begin
        ok = lw ? m_w[h] : m_r[h];
        if (ok) begin e_hit = 1; e_pa = {m_ppn[h], va[11:0]}; end
        else e_fault = 1;
      end
    end
    fh = find_tag(fvpn);
    sel = (fh >= 0) ? fh : pick_victim(wrap);
    if (fh >= 0) wrap = 1'b0;
    e_ev = fv && !inv && fh < 0 && m_v[sel];
    e_evv = m_tag[sel];
    e_evd = m_d[sel];
    if (e_hit) begin m_ref[h] = 1; if (lw) m_d[h] = 1; end
    if (fv && !inv) begin
      if (wrap) for (int i = 0; i < N; i++) m_ref[i] = 0;
      m_v[sel] = 1; m_d[sel] = 0; m_ref[sel] = 0;
      m_tag[sel] = fvpn; m_ppn[sel] = fppn; m_r[sel] = fr; m_w[sel] = fw;
    end
    if (inv) for (int i = 0; i < N; i++) m_v[i] = 0;
    @(posedge clk);
    @(negedge clk);
    t = (req != "") ? req : (e_hit ? "R2" : (e_fault ? "R4" : "R3"));
    chk(t, "rsp_valid", 64'(rsp_valid), 64'(lv));
    if (lv) begin
      chk(t, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
      chk(t, "rsp_miss", 64'(rsp_miss), 64'(e_miss));
      chk(t, "rsp_fault", 64'(rsp_fault), 64'(e_fault));
      chk(t, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    end
    t = (req != "") ? req : "R12";
    chk(t, "ev_valid", 64'(ev_valid), 64'(e_ev));
    if (e_ev) begin
      chk(t, "ev_vpn", 64'(ev_vpn), 64'(e_evv));
      chk(t, "ev_dirty", 64'(ev_dirty), 64'(e_evd));
    end
  endtask

  task automatic look(bit [31:0] va, bit w, string req);
    step(1, va, w, 0, '0, '0, 0, 0, 0, req);
  endtask

  task automatic fill(bit [19:0] vpn, bit [19:0] ppn, bit r, bit w, string req);
    step(0, '0, 0, 1, vpn, ppn, r, w, 0, req);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1f2e3d4c;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_ref[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset, then first lookup misses
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R1", "ev_valid", 64'(ev_valid), 64'(0));
    look(32'h1234_5678, 0, "R1");
    // R6: first fills go to slots 0 and 1
    fill(20'h12345, 20'hABCDE, 1, 1, "R6");
    look(32'h1234_5678, 0, "R2");
    fill(20'h00001, 20'h00111, 1, 0, "R6");
    look(32'h0000_1ABC, 1, "R4");
    look(32'h0000_1ABC, 0, "R2");
    look(32'h1234_5FFF, 1, "R5");
    // R9: same tag rewritten in place, no eviction report
    fill(20'h00001, 20'h00222, 1, 1, "R9");
    look(32'h0000_1004, 1, "R9");
    // R6: fill slots 2..63
    for (int i = 2; i < N; i++) fill(20'h40000 + 20'(i), 20'h50000 + 20'(i), 1, 1, "R6");
    // R7: slot 2 is the lowest with clear reference
    fill(20'h77777, 20'h01010, 1, 1, "R7");
    // R11: lookup and rewrite of the same tag in one cycle
    step(1, 32'h4000_3123, 0, 1, 20'h40003, 20'h0BEEF, 1, 0, 0, "R11");
    look(32'h4000_3123, 0, "R11");
    // R8: touch every slot, then a new tag wraps to slot 0 (dirty)
    look(32'h7777_7000, 0, "R8");
    look(32'h1234_5000, 0, "R8");
    look(32'h0000_1000, 0, "R8");
    for (int i = 3; i < N; i++) look({20'h40000 + 20'(i), 12'h0}, 0, "R8");
    fill(20'h66666, 20'h02020, 1, 1, "R8");
    // R10: invalidate drops all and a same-cycle fill
    step(0, '0, 0, 1, 20'h55555, 20'h03030, 1, 1, 1, "R10");
    look(32'h5555_5000, 0, "R10");
    look(32'h0000_1000, 0, "R10");
    fill(20'h55555, 20'h03030, 1, 1, "R10");
    // Random mix over a tag space larger than the table
    for (int k = 0; k < 4000; k++) begin
      bit lv, fv, inv;
      bit [19:0] a, b;
      lv  = ($urandom % 4) != 0;
      fv  = ($urandom % 3) == 0;
      inv = ($urandom % 300) == 0;
      a   = 20'(($urandom % 80) + 20'h30000);
      b   = 20'(($urandom % 80) + 20'h30000);
      step(lv, {a, 12'($urandom)}, 1'($urandom), fv, b, 20'($urandom),
           1'($urandom % 4 != 0), 1'($urandom), inv, "");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule